// File: doc/BRIEF.md
# LIN Response Reception Sequencer

This block runs the receive side of a LIN frame response for a bus master once the header has been sent. A start command arms it with a byte count, a checksum flavour and the protected identifier that went out in the header. After that it takes bytes one at a time from a UART byte receiver. The receiver hands over each byte as a single-cycle valid strobe with a data byte and a framing-error bit. Each data byte is written into a small buffer at the slot that matches its position in the response, and it is also folded into a running checksum. The block then takes one last byte and compares it against that checksum.

Software watches four sticky indications. The first indication rises as soon as the first data byte is in. The second reports a good frame, the third a checksum mismatch, and the fourth an aborted response. A non-zero value on the external error-status bus stops reception at once and skips the checksum comparison. A framing error on any received byte does the same. The frame-active bit clears itself when the response ends, and software may read the buffer at any time afterwards.

Top module: `lin_resp_rx`

## Requirements
- R1: After reset the frame-active output and all four indications are 0. A start pulse while idle sets frame-active in the next cycle.
- R2: The cycle after the first data byte is accepted, the first-byte indication is 1, while the frame-success indication is still 0.
- R3: The 4-bit length code is latched at start. Codes 0 to 7 select 1 to 8 data bytes, and any code of 8 or more selects 8 data bytes.
- R4: Any number of idle cycles may separate bytes. Data byte k (counting from 0) is stored in buffer slot k, and the read port returns it combinationally after the frame has ended.
- R5: In classic mode (mode input 0), the expected checksum is the bitwise inverse of the 8-bit sum with end-around carry over the data bytes. When the byte after the last data byte equals it, frame-success is set and frame-active clears in the same cycle.
- R6: In enhanced mode (mode input 1), the protected identifier is included in that sum as its first term.
- R7: A checksum mismatch sets the checksum-error indication, leaves frame-success at 0 and clears frame-active.
- R8: A non-zero error-status value, or a byte strobe with its framing-error bit set, while frame-active ends the response. Abort is set, frame-active clears and no checksum comparison takes place, so a byte arriving afterwards changes no indication.
- R9: A start pulse while frame-active is ignored, and the length latched for the current frame stays in force.
- R10: All four indications hold until a one-cycle clear pulse. A new event in the same cycle as the clear pulse wins over it.
- R11: A byte strobe while idle does not write the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for response reception |
| len_code_i | input | 4 | Data length code, latched at start |
| enh_mode_i | input | 1 | 1 = enhanced checksum, 0 = classic |
| pid_i | input | 8 | Protected identifier used in the enhanced sum |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_data_i | input | 8 | Received byte |
| byte_ferr_i | input | 1 | Framing error for the strobed byte |
| err_stat_i | input | 4 | Error status bits, any 1 aborts |
| flag_clr_i | input | 1 | Clears all indications |
| rd_idx_i | input | 3 | Buffer read slot |
| rd_data_o | output | 8 | Buffer read data |
| busy_o | output | 1 | Frame-active bit |
| first_ok_o | output | 1 | First data byte received |
| frame_ok_o | output | 1 | Frame received with good checksum |
| cks_err_o | output | 1 | Checksum mismatch |
| abort_o | output | 1 | Response aborted by error |

## Verification
The bench builds the block with its default parameters: an 8-slot buffer, a 4-bit length code, a 4-bit error bus, enhanced mode enabled and buffer reset enabled. With a 4-bit code against 8 slots, codes 8 to 15 can be driven, so the clamp to 8 bytes is exercised alongside the shortest 1-byte response. The enhanced-mode variant makes the identifier term in the checksum observable. Aborts are placed before the first byte, in the middle of the data and during the checksum wait, which separates the first-byte indication from the abort path.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_DATA = 2'd1,
      SQ_CKS  = 2'd2
   } seq_st_t;

   // 8-bit addition with the carry folded back into bit 0
   function automatic logic [7:0] eac_add(input logic [7:0] a, input logic [7:0] b);
      logic [8:0] t;
      t = {1'b0, a} + {1'b0, b};
      return t[7:0] + {7'd0, t[8]};
   endfunction

endpackage

// File: rtl/lin_resp_cksum.sv
module lin_resp_cksum #(
   parameter int DW     = 8,
   parameter bit ENH_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_i,
   input  logic          enh_i,
   input  logic [DW-1:0] pid_i,
   input  logic          add_i,
   input  logic [DW-1:0] byte_i,
   output logic [DW-1:0] expect_o
);
   import lin_resp_pkg::*;

   logic [DW-1:0] sum_q;
   logic [DW-1:0] seed;

   generate
      if (ENH_EN) begin : g_enh
         assign seed = enh_i ? pid_i : '0;
      end else begin : g_classic
         logic unused_enh;
         assign unused_enh = enh_i ^ (|pid_i);
         assign seed = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (init_i) begin
         sum_q <= seed;
      end else if (add_i) begin
         sum_q <= eac_add(sum_q, byte_i);
      end
   end

   assign expect_o = ~sum_q;

   // A start clears the running sum to the seed value
   AST_INIT_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      (init_i && !enh_i) |=> (expect_o == '1)); // R5

endmodule

// File: rtl/lin_resp_buf.sv
module lin_resp_buf #(
   parameter int DW      = 8,
   parameter int DEPTH   = 8,
   parameter bit BUF_RST = 1'b1,
   localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic [IW-1:0] rd_idx_i,
   output logic [DW-1:0] rd_data_o
);
   logic [DW-1:0] slot_q [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic hit;
         assign hit = wr_i && (wr_idx_i == IW'(g));
         if (BUF_RST) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   slot_q[g] <= '0;
               else if (hit) slot_q[g] <= wr_data_i;
            end
         end else begin : g_nrst
            always_ff @(posedge clk) begin
               if (hit) slot_q[g] <= wr_data_i;
            end
         end
      end
   endgenerate

   assign rd_data_o = (int'(rd_idx_i) < DEPTH) ? slot_q[rd_idx_i] : '0;

   AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |-> (int'(wr_idx_i) < DEPTH)); // R4

   AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (slot_q[$past(wr_idx_i)] == $past(wr_data_i))); // R4

endmodule

// File: rtl/lin_resp_seq.sv
module lin_resp_seq #(
   parameter int DW     = 8,
   parameter int DEPTH  = 8,
   parameter int LENW   = 4,
   parameter int ERRW   = 4,
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [LENW-1:0] len_code_i,
   input  logic            byte_vld_i,
   input  logic [DW-1:0]   byte_data_i,
   input  logic            byte_ferr_i,
   input  logic [ERRW-1:0] err_stat_i,
   input  logic            flag_clr_i,
   input  logic [DW-1:0]   cks_expect_i,
   output logic            cks_init_o,
   output logic            cks_add_o,
   output logic            wr_o,
   output logic [IW-1:0]   wr_idx_o,
   output logic            busy_o,
   output logic            first_ok_o,
   output logic            frame_ok_o,
   output logic            cks_err_o,
   output logic            abort_o
);
   import lin_resp_pkg::*;

   localparam logic [LENW:0] DEPTH_L = (LENW + 1)'(DEPTH);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   seq_st_t       st_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] nb_q;
   logic [CW-1:0] nb_dec;
   logic          fault;
   logic          take;

   // Length code to byte count, clamped at the buffer depth
   always_comb begin
      if ({1'b0, len_code_i} >= DEPTH_L) nb_dec = DEPTH_C;
      else                               nb_dec = CW'(len_code_i) + CW'(1);
   end

   assign busy_o     = (st_q != SQ_IDLE);
   assign fault      = busy_o && ((|err_stat_i) || (byte_vld_i && byte_ferr_i));
   assign take       = busy_o && byte_vld_i && !fault;
   assign cks_init_o = (st_q == SQ_IDLE) && start_i;
   assign wr_o       = take && (st_q == SQ_DATA);
   assign cks_add_o  = wr_o;
   assign wr_idx_o   = IW'(cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= SQ_IDLE;
         cnt_q      <= '0;
         nb_q       <= '0;
         first_ok_o <= 1'b0;
         frame_ok_o <= 1'b0;
         cks_err_o  <= 1'b0;
         abort_o    <= 1'b0;
      end else begin
         if (flag_clr_i) begin
            first_ok_o <= 1'b0;
            frame_ok_o <= 1'b0;
            cks_err_o  <= 1'b0;
            abort_o    <= 1'b0;
         end
         unique case (st_q)
            SQ_IDLE: begin
               if (start_i) begin
                  st_q  <= SQ_DATA;
                  cnt_q <= '0;
                  nb_q  <= nb_dec;
               end
            end
            SQ_DATA: begin
               if (fault) begin
                  abort_o <= 1'b1;
                  st_q    <= SQ_IDLE;
               end else if (take) begin
                  cnt_q <= cnt_q + CW'(1);
                  if (cnt_q == '0) first_ok_o <= 1'b1;
                  if (cnt_q + CW'(1) == nb_q) st_q <= SQ_CKS;
               end
            end
            SQ_CKS: begin
               if (fault) begin
                  abort_o <= 1'b1;
                  st_q    <= SQ_IDLE;
               end else if (take) begin
                  if (byte_data_i == cks_expect_i) frame_ok_o <= 1'b1;
                  else                             cks_err_o  <= 1'b1;
                  st_q <= SQ_IDLE;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o); // R1

   AST_FIRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_o && cnt_q == '0) |=> first_ok_o); // R2

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cnt_q <= nb_q)); // R3

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_ok_o) |-> !busy_o); // R5

   AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (|err_stat_i)) |=> (!busy_o && abort_o)); // R8

   AST_ABORT_NO_CKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_o) |-> (!$rose(frame_ok_o) && !$rose(cks_err_o))); // R8

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(nb_q)); // R9

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_o); // R11

endmodule

// File: rtl/lin_resp_rx.sv
module lin_resp_rx #(
   parameter int DW      = 8,
   parameter int DEPTH   = 8,
   parameter int LENW    = 4,
   parameter int ERRW    = 4,
   parameter bit ENH_EN  = 1'b1,
   parameter bit BUF_RST = 1'b1,
   localparam int IW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [LENW-1:0] len_code_i,
   input  logic            enh_mode_i,
   input  logic [DW-1:0]   pid_i,
   input  logic            byte_vld_i,
   input  logic [DW-1:0]   byte_data_i,
   input  logic            byte_ferr_i,
   input  logic [ERRW-1:0] err_stat_i,
   input  logic            flag_clr_i,
   input  logic [IW-1:0]   rd_idx_i,
   output logic [DW-1:0]   rd_data_o,
   output logic            busy_o,
   output logic            first_ok_o,
   output logic            frame_ok_o,
   output logic            cks_err_o,
   output logic            abort_o
);

   generate
      if (DW != 8) begin : g_bad_dw
         $error("lin_resp_rx: byte width must be 8");
      end
      if (DEPTH < 1 || DEPTH > 16) begin : g_bad_depth
         $error("lin_resp_rx: buffer depth out of range");
      end
      if ((1 << LENW) < DEPTH) begin : g_bad_len
         $error("lin_resp_rx: length code too narrow for depth");
      end
      if (ERRW < 1) begin : g_bad_err
         $error("lin_resp_rx: error bus needs at least one bit");
      end
   endgenerate

   logic          cks_init;
   logic          cks_add;
   logic [DW-1:0] cks_expect;
   logic          wr;
   logic [IW-1:0] wr_idx;

   lin_resp_seq #(
      .DW(DW), .DEPTH(DEPTH), .LENW(LENW), .ERRW(ERRW)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .len_code_i   (len_code_i),
      .byte_vld_i   (byte_vld_i),
      .byte_data_i  (byte_data_i),
      .byte_ferr_i  (byte_ferr_i),
      .err_stat_i   (err_stat_i),
      .flag_clr_i   (flag_clr_i),
      .cks_expect_i (cks_expect),
      .cks_init_o   (cks_init),
      .cks_add_o    (cks_add),
      .wr_o         (wr),
      .wr_idx_o     (wr_idx),
      .busy_o       (busy_o),
      .first_ok_o   (first_ok_o),
      .frame_ok_o   (frame_ok_o),
      .cks_err_o    (cks_err_o),
      .abort_o      (abort_o)
   );

   lin_resp_cksum #(
      .DW(DW), .ENH_EN(ENH_EN)
   ) u_cksum (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_i   (cks_init),
      .enh_i    (enh_mode_i),
      .pid_i    (pid_i),
      .add_i    (cks_add),
      .byte_i   (byte_data_i),
      .expect_o (cks_expect)
   );

   lin_resp_buf #(
      .DW(DW), .DEPTH(DEPTH), .BUF_RST(BUF_RST)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr),
      .wr_idx_i  (wr_idx),
      .wr_data_i (byte_data_i),
      .rd_idx_i  (rd_idx_i),
      .rd_data_o (rd_data_o)
   );

   AST_OUTCOME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cks_err_o) |-> !$rose(frame_ok_o)); // R7

   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_ok_o && !flag_clr_i) |=> frame_ok_o); // R10

endmodule

// File: tb/lin_resp_rx_bench.sv
module lin_resp_rx_bench;

   typedef struct {
      logic first;
      logic ok;
      logic ckerr;
      logic abrt;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [3:0] len_code_i = '0;
   logic       enh_mode_i = 1'b0;
   logic [7:0] pid_i = '0;
   logic       byte_vld_i = 1'b0;
   logic [7:0] byte_data_i = '0;
   logic       byte_ferr_i = 1'b0;
   logic [3:0] err_stat_i = '0;
   logic       flag_clr_i = 1'b0;
   logic [2:0] rd_idx_i = '0;
   logic [7:0] rd_data_o;
   logic       busy_o, first_ok_o, frame_ok_o, cks_err_o, abort_o;

   int   n_chk = 0;
   int   n_err = 0;
   exp_t exp_q[$];
   logic busy_prev = 1'b0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   lin_resp_rx u_lin_resp_rx (
      .clk, .rst_n, .start_i, .len_code_i, .enh_mode_i, .pid_i,
      .byte_vld_i, .byte_data_i, .byte_ferr_i, .err_stat_i, .flag_clr_i,
      .rd_idx_i, .rd_data_o, .busy_o, .first_ok_o, .frame_ok_o,
      .cks_err_o, .abort_o
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] eac(input logic [7:0] a, input logic [7:0] b);
      int s;
      s = int'(a) + int'(b);
      if (s > 255) s = s - 255;
      return 8'(s);
   endfunction

   // Monitor: each time the frame-active bit falls, compare the outcome
   always @(negedge clk) begin
      if (rst_n && busy_prev && !busy_o) begin
         if (exp_q.size() == 0) begin
            chk("R1 unexpected frame end", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R2 first flag at end", 32'(first_ok_o), 32'(e.first));
            chk("R5 frame ok at end", 32'(frame_ok_o), 32'(e.ok));
            chk("R7 checksum error at end", 32'(cks_err_o), 32'(e.ckerr));
            chk("R8 abort at end", 32'(abort_o), 32'(e.abrt));
         end
      end
      busy_prev = busy_o;
   end

   task automatic send_byte(input logic [7:0] b, input logic ferr, input int gap);
      repeat (gap) @(negedge clk);
      @(negedge clk);
      byte_vld_i  = 1'b1;
      byte_data_i = b;
      byte_ferr_i = ferr;
      @(negedge clk);
      byte_vld_i  = 1'b0;
      byte_ferr_i = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
   endtask

   task automatic pulse_start(input logic [3:0] code, input logic enh, input logic [7:0] pid);
      @(negedge clk);
      start_i    = 1'b1;
      len_code_i = code;
      enh_mode_i = enh;
      pid_i      = pid;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Driver: err_at < 0 means no error; err_at == k injects before byte k
   task automatic run_frame(input logic [3:0] code, input logic enh, input logic [7:0] pid,
                            input int seed, input int err_at, input logic ferr_mode,
                            input logic bad_cks, input int gap);
      int         n;
      logic [7:0] d [8];
      logic [7:0] s;
      exp_t       e;
      n = (code >= 4'd8) ? 8 : int'(code) + 1;
      s = enh ? pid : 8'h00;
      for (int i = 0; i < 8; i++) d[i] = 8'(seed * 37 + i * 91 + 5);
      for (int i = 0; i < n; i++) s = eac(s, d[i]);
      e.first = (err_at != 0);
      e.ok    = (err_at < 0) && !bad_cks;
      e.ckerr = (err_at < 0) && bad_cks;
      e.abrt  = (err_at >= 0);
      pulse_clr();
      exp_q.push_back(e);
      pulse_start(code, enh, pid);
      chk("R1 frame-active after start", 32'(busy_o), 32'd1);
      for (int i = 0; i <= n; i++) begin
         if (i == err_at) begin
            if (ferr_mode) begin
               send_byte(8'h55, 1'b1, gap);
            end else begin
               @(negedge clk);
               err_stat_i = 4'b0100;
               @(negedge clk);
               err_stat_i = 4'b0000;
            end
            chk("R8 frame-active cleared on error", 32'(busy_o), 32'd0);
            send_byte(~s, 1'b0, 1);
            chk("R8 late byte leaves frame ok", 32'(frame_ok_o), 32'd0);
            chk("R8 late byte leaves checksum error", 32'(cks_err_o), 32'd0);
            break;
         end
         if (i < n) begin
            send_byte(d[i], 1'b0, gap);
            if (i == 0) begin
               chk("R2 first flag after byte 1", 32'(first_ok_o), 32'd1);
               chk("R2 frame ok not yet", 32'(frame_ok_o), 32'd0);
            end
         end else begin
            send_byte(bad_cks ? (~s ^ 8'h01) : ~s, 1'b0, gap);
            chk("R5 frame-active cleared at end", 32'(busy_o), 32'd0);
         end
      end
      @(negedge clk);
      if (err_at < 0 && !bad_cks) begin
         for (int i = 0; i < n; i++) begin
            rd_idx_i = 3'(i);
            #1;
            chk("R4 buffer slot", 32'(rd_data_o), 32'(d[i]));
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         chk("watchdog", 32'd1, 32'd0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset frame-active", 32'(busy_o), 32'd0);
      chk("R1 reset flags", 32'({first_ok_o, frame_ok_o, cks_err_o, abort_o}), 32'd0);

      // R11: idle byte strobe must not write slot 0
      send_byte(8'hA7, 1'b0, 0);
      rd_idx_i = 3'd0;
      #1;
      chk("R11 idle byte not stored", 32'(rd_data_o), 32'd0);
      chk("R11 idle byte no flag", 32'(first_ok_o), 32'd0);

      run_frame(4'd3, 1'b0, 8'h00, 1, -1, 1'b0, 1'b0, 0);  // R5 classic
      run_frame(4'd7, 1'b1, 8'h97, 2, -1, 1'b0, 1'b0, 2);  // R6 enhanced, gaps R4
      run_frame(4'd0, 1'b0, 8'h00, 3, -1, 1'b0, 1'b0, 0);  // R3 one byte
      run_frame(4'd15, 1'b1, 8'h3C, 4, -1, 1'b0, 1'b0, 1); // R3 clamp to 8
      run_frame(4'd9, 1'b0, 8'h00, 9, -1, 1'b0, 1'b0, 0);  // R3 clamp to 8
      run_frame(4'd4, 1'b1, 8'h11, 5, -1, 1'b0, 1'b1, 0);  // R7 mismatch
      run_frame(4'd5, 1'b0, 8'h00, 6, 3, 1'b0, 1'b0, 0);   // R8 mid data
      run_frame(4'd2, 1'b0, 8'h00, 7, 0, 1'b0, 1'b0, 0);   // R8 before byte 1
      run_frame(4'd2, 1'b1, 8'h42, 8, 3, 1'b0, 1'b0, 1);   // R8 at checksum
      run_frame(4'd6, 1'b0, 8'h00, 10, 2, 1'b1, 1'b0, 0);  // R8 framing error

      // R10: indications hold, then clear
      repeat (5) @(negedge clk);
      chk("R10 abort holds", 32'(abort_o), 32'd1);
      pulse_clr();
      chk("R10 cleared by pulse", 32'({first_ok_o, frame_ok_o, cks_err_o, abort_o}), 32'd0);

      // R9: start while active with another length is ignored (2 bytes stay)
      begin
         logic [7:0] s;
         exp_t       e;
         s = eac(8'h00, 8'h12);
         s = eac(s, 8'hF3);
         e.first = 1'b1; e.ok = 1'b1; e.ckerr = 1'b0; e.abrt = 1'b0;
         exp_q.push_back(e);
         pulse_start(4'd1, 1'b0, 8'h00);
         send_byte(8'h12, 1'b0, 0);
         pulse_start(4'd6, 1'b0, 8'h00);
         send_byte(8'hF3, 1'b0, 0);
         send_byte(~s, 1'b0, 0);
         chk("R9 frame ended on original length", 32'(busy_o), 32'd0);
         chk("R9 frame ok", 32'(frame_ok_o), 32'd1);
      end

      repeat (3) @(negedge clk);
      chk("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule